// File: doc/BRIEF.md
# Channel Presence Detect and Interrupt Monitor

This block sits between six peripheral devices and a local processor. Each device owns one active-low interrupt line, and a channel with no device fitted has its line tied low. A fitted device must hold its line inactive (high) while it comes out of reset. The block uses that property: a fixed number of clock cycles after its own reset is released, it samples every synchronized line once. It records each channel that reads high as present and each channel that reads low as absent. This presence mask then holds until the next reset. While the block is settling, it holds a reset output to the local bus low.

Once presence is known, interrupts from fitted devices are forwarded. Each line is resynchronized and inverted to an active-high bit, and the bit is gated by the presence mask. The result forms the pending vector. A grounded channel therefore never shows as pending.

Next to this path, the block keeps a small interrupt register that the host writes. Each 1 the host writes sets the matching bit, and a 0 leaves the bit unchanged. The local processor reads the register through a read strobe, and that read clears it. The local interrupt output is high while any register bit is set or any pending bit is high.

Top module: `chan_irq_monitor`

## Requirements
- R1: While `rst_n` is low, and until presence is captured, `present_mask` and `pending` read all zeros and `lbus_rst_n` is low. Reset also clears the host interrupt register, so `loc_rd_data` reads 0.
- R2: The presence mask is captured on the 16th rising clock edge with `rst_n` high. `lbus_rst_n` goes high on that same edge. Bit i of the mask is 1 when `irq_n[i]` was high (fitted device) and 0 when it was low.
- R3: After capture, `present_mask` does not change until the next reset, whatever the interrupt lines do.
- R4: A channel captured as absent never sets its bit in `pending`, even while its line is low.
- R5: For a present channel i, `pending[i]` is the inverse of `irq_n[i]`, delayed through two flops. A change driven between edges appears after the second following rising edge and not after the first.
- R6: A host write (`host_wr_en` high) ORs `host_wr_data` into the 8-bit interrupt register. Data bits that are 0 leave the matching register bits unchanged.
- R7: `local_irq` is high exactly when the interrupt register is nonzero or any bit of `pending` is high.
- R8: `loc_rd_data` always shows the current register contents. A cycle with `loc_rd_en` high and no write clears the register at the next edge.
- R9: When a read and a write fall in the same cycle, the read returns the old contents. After the edge the register holds exactly the written data.
- R10: Every reset discards the previous mask, and presence is sampled again as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_n | input | 6 | Device interrupt lines, active low, asynchronous |
| host_wr_en | input | 1 | Host write strobe for the interrupt register |
| host_wr_data | input | 8 | Bits to set in the interrupt register |
| loc_rd_en | input | 1 | Local processor read strobe; clears the register |
| loc_rd_data | output | 8 | Current interrupt register contents |
| present_mask | output | 6 | 1 = device fitted on that channel |
| pending | output | 6 | Active-high interrupts from fitted devices |
| local_irq | output | 1 | Interrupt to the local processor |
| lbus_rst_n | output | 1 | Local bus reset, low until presence is captured |

## Verification
The bench runs all 64 line patterns through a full reset and capture sequence. For each one it checks the mask on every edge of the settling window, which shows whether sampling happens on the correct edge and whether absent channels are told apart from present ones. For each pattern it then pulls each channel low in turn and also drives the inverted pattern. This shows whether gating by the mask works, whether the two-edge delay is correct, and whether the mask stays fixed after capture. The host register is tried with all 256 single-write values, with pairs of overlapping writes that test OR-setting, and with a write that lands in the same cycle as a read, which shows that the write takes priority over the clear.

// File: rtl/chan_irq_pkg.sv
// Package: shared types for the channel presence and interrupt monitor.
// Assumes nothing beyond IEEE 1800-2017 packages.
package chan_irq_pkg;

    // Presence detector phase: counting out the settle window, or mask fixed.
    typedef enum logic {
        PD_SETTLE = 1'b0,
        PD_LOCKED = 1'b1
    } pd_state_e;

endpackage

// File: rtl/cim_sync_bank.sv
// Module: cim_sync_bank
// A bank of WIDTH independent flop chains that resynchronize asynchronous
// level inputs into the clk domain. Each chain is STAGES flops long.
// Assumes: inputs are quasi-static levels, and no bus coherency is needed
// across bits. Reset loads RST_VAL into every stage, so lines that are
// active low start out inactive.
module cim_sync_bank #(
    parameter int          WIDTH   = 6,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw level through the chain of flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL}};
            end else begin
                chain <= {chain[STAGES-2:0], async_in[b]};
            end
        end

        assign sync_out[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/cim_presence.sv
// Module: cim_presence
// Counts SETTLE clock edges after reset is released. On the last of them,
// it captures which synchronized interrupt lines are high (device fitted)
// and then holds that mask until the next reset.
// Assumes: fitted devices keep their lines high through the settle window,
// and unused channels are tied low.
module cim_presence
    import chan_irq_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int SETTLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] line_sync_n,
    output logic [NUM_CH-1:0] present_mask,
    output logic              locked
);

    localparam int          CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1);

    pd_state_e        state;
    logic [CNT_W-1:0] cnt;

    // Count the settle window, then capture the mask once and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= PD_SETTLE;
            cnt          <= '0;
            present_mask <= '0;
        end else if (state == PD_SETTLE) begin
            if (cnt == LAST) begin
                present_mask <= line_sync_n;
                state        <= PD_LOCKED;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign locked = (state == PD_LOCKED);

    // R1: no channel reads as present before capture.
    a_r1_mask_clear_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (present_mask == '0));

    // R2: the lock arrives only on the edge where the count reached its last value.
    a_r2_lock_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(cnt) == LAST));

    // R3: once locked, the mask never moves.
    a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(present_mask));

endmodule

// File: rtl/cim_host_irq.sv
// Module: cim_host_irq
// The host-writable interrupt register. A write ORs its data into the
// register, and a local read clears it. When both happen in the same
// cycle, the written bits win.
// Assumes: strobes are single-cycle qualified and synchronous to clk.
module cim_host_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         any_set
);

    logic [W-1:0] bits_q;
    logic [W-1:0] kept;
    logic [W-1:0] added;

    // Bits that survive this cycle: a read drops them all.
    always_comb kept  = rd_en ? '0 : bits_q;
    // Bits that this cycle's write sets.
    always_comb added = wr_en ? wr_data : '0;

    // Update the register from the surviving and newly set bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= kept | added;
        end
    end

    assign rd_data = bits_q;
    assign any_set = |bits_q;

    // R9: every bit a write sets is present after the edge, read or not.
    a_r9_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((bits_q & $past(wr_data)) == $past(wr_data)));

    // R8: a read with no write empties the register.
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> (bits_q == '0));

    // R6: with no strobe, the contents hold.
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |=> $stable(bits_q));

endmodule

// File: rtl/chan_irq_monitor.sv
// Module: chan_irq_monitor (top)
// Synchronizes the device interrupt lines, detects which devices are fitted
// after reset, forwards interrupts from fitted devices as an active-high
// pending vector, and combines them with the host interrupt register into
// one local processor interrupt. It also drives the local bus reset until
// presence is known.
// Assumes: rst_n is synchronous to clk; irq_n may be asynchronous.
module chan_irq_monitor #(
    parameter int NUM_CH      = 6,
    parameter int SETTLE      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int HREG_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] irq_n,
    input  logic              host_wr_en,
    input  logic [HREG_W-1:0] host_wr_data,
    input  logic              loc_rd_en,
    output logic [HREG_W-1:0] loc_rd_data,
    output logic [NUM_CH-1:0] present_mask,
    output logic [NUM_CH-1:0] pending,
    output logic              local_irq,
    output logic              lbus_rst_n
);

    logic [NUM_CH-1:0] line_sync_n;
    logic              locked;
    logic              host_any;

    // Resynchronize the raw device lines.
    cim_sync_bank #(
        .WIDTH   (NUM_CH),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_n),
        .sync_out (line_sync_n)
    );

    // Decide once which channels carry a device.
    cim_presence #(
        .NUM_CH (NUM_CH),
        .SETTLE (SETTLE)
    ) u_presence (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_sync_n  (line_sync_n),
        .present_mask (present_mask),
        .locked       (locked)
    );

    // Host-set, locally-cleared interrupt register.
    cim_host_irq #(
        .W (HREG_W)
    ) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr_en),
        .wr_data (host_wr_data),
        .rd_en   (loc_rd_en),
        .rd_data (loc_rd_data),
        .any_set (host_any)
    );

    // Forward active interrupts from fitted channels only.
    always_comb pending = ~line_sync_n & present_mask;

    // Raise the local interrupt for any register bit or any pending device.
    always_comb local_irq = host_any | (|pending);

    // Hold the local bus in reset until presence is known.
    assign lbus_rst_n = locked;

    // R4: an absent channel never shows up as pending.
    a_r4_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & ~present_mask) == '0);

    // R7: a write of any set bit raises the local interrupt after the edge.
    a_r7_write_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && (|host_wr_data)) |=> local_irq);

    // R2: the local bus leaves reset only together with a captured mask.
    a_r2_bus_reset_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lbus_rst_n) |-> $changed(present_mask) || (present_mask == '0));

endmodule

// File: tb/tb_chan_irq_monitor.sv
module tb_chan_irq_monitor;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] irq_n;
    logic       host_wr_en;
    logic [7:0] host_wr_data;
    logic       loc_rd_en;
    logic [7:0] loc_rd_data;
    logic [5:0] present_mask;
    logic [5:0] pending;
    logic       local_irq;
    logic       lbus_rst_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    chan_irq_monitor dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_n        (irq_n),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .loc_rd_en    (loc_rd_en),
        .loc_rd_data  (loc_rd_data),
        .present_mask (present_mask),
        .pending      (pending),
        .local_irq    (local_irq),
        .lbus_rst_n   (lbus_rst_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic host_write(input logic [7:0] v);
        host_wr_en   = 1'b1;
        host_wr_data = v;
        step();
        host_wr_en   = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; irq_n = '1; host_wr_en = 1'b0; host_wr_data = '0; loc_rd_en = 1'b0;
        step();
        for (int p = 0; p < 64; p++) begin
            logic [5:0] pat;
            pat = 6'(p);
            // leave something in the host register so reset must clear it
            if (rst_n) host_write(8'hA5);
            irq_n = pat;
            rst_n = 1'b0;
            repeat (3) step();
            chk(present_mask == 0, "R1 mask in reset", present_mask, 0);
            chk(pending == 0, "R1 pending in reset", pending, 0);
            chk(lbus_rst_n == 1'b0, "R1 bus reset low", lbus_rst_n, 0);
            chk(loc_rd_data == 0, "R1 host reg cleared", loc_rd_data, 0);
            rst_n = 1'b1;
            for (int j = 1; j <= 16; j++) begin
                step();
                if (j < 16) begin
                    chk(present_mask == 0, "R1 mask before capture", present_mask, 0);
                    chk(lbus_rst_n == 1'b0, "R1 bus reset held", lbus_rst_n, 0);
                end else begin
                    chk(present_mask == pat, "R2 R10 captured mask", present_mask, pat);
                    chk(lbus_rst_n == 1'b1, "R2 bus reset released", lbus_rst_n, 1);
                end
            end
            chk(pending == 0, "R4 absent lines low but quiet", pending, 0);
            for (int i = 0; i < 6; i++) begin
                logic [5:0] exp;
                exp = pat & 6'(1 << i);
                irq_n[i] = 1'b0;
                step();
                chk(pending == 0, "R5 not visible after one edge", pending, 0);
                step();
                chk(pending == exp, "R4 R5 pending after two edges", pending, exp);
                chk(local_irq == (exp != 0), "R7 irq from pending", local_irq, exp != 0);
                irq_n[i] = pat[i];
                step(); step();
                chk(pending == 0, "R5 pending drops", pending, 0);
            end
            irq_n = ~pat;
            step(); step();
            chk(present_mask == pat, "R3 mask held", present_mask, pat);
            chk(pending == pat, "R3 R4 inverted lines", pending, pat);
            chk(local_irq == (pat != 0), "R7 irq inverted lines", local_irq, pat != 0);
            irq_n = pat;
            step(); step();
        end

        // all channels present, lines idle: host register sweep
        for (int v = 0; v < 256; v++) begin
            host_write(8'(v));
            chk(loc_rd_data == 8'(v), "R6 written value", loc_rd_data, v);
            chk(local_irq == (v != 0), "R7 irq from register", local_irq, v != 0);
            loc_rd_en = 1'b1;
            #1;
            chk(loc_rd_data == 8'(v), "R8 read shows contents", loc_rd_data, v);
            step();
            loc_rd_en = 1'b0;
            chk(loc_rd_data == 0, "R8 read clears", loc_rd_data, 0);
            chk(local_irq == 1'b0, "R7 irq drops after read", local_irq, 0);
        end

        for (int k = 0; k < 16; k++) begin
            logic [7:0] a, b;
            a = 8'(k * 37 + 1);
            b = 8'(k * 91 + 6);
            host_write(a);
            host_write(b);
            chk(loc_rd_data == (a | b), "R6 OR-set", loc_rd_data, a | b);
            // write colliding with read
            host_wr_en = 1'b1; host_wr_data = a; loc_rd_en = 1'b1;
            #1;
            chk(loc_rd_data == (a | b), "R9 read returns old", loc_rd_data, a | b);
            step();
            host_wr_en = 1'b0; loc_rd_en = 1'b0;
            chk(loc_rd_data == a, "R9 write wins", loc_rd_data, a);
            loc_rd_en = 1'b1;
            step();
            loc_rd_en = 1'b0;
            chk(loc_rd_data == 0, "R8 cleared again", loc_rd_data, 0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule